// File: doc/BRIEF.md
# SD Card Data FIFO with Fill Thresholds

This block is the 16-word, 32-bit staging buffer that sits between the host's data register and the SD card data-line engine. It works in one of two directions, chosen by `dir_rd`.

- **Card-to-host (read) direction:** the line engine pushes words into the FIFO through a valid/ready port, and software pops them by reading the data register.
- **Host-to-card (write) direction:** software pushes words by writing the data register, and the line engine drains them through a second valid/ready port.

A mode register word reports three 5-bit fields: the current fill level, the write threshold and the read threshold. Two ready outputs compare the fill level against these thresholds so that software can move data in bursts.

Misuse from the register side is not silently absorbed. A pop from an empty FIFO returns zero, a push into a full FIFO is discarded, and either event sets a sticky FIFO error flag in the status word.

The line side can never overflow or underflow because it is handshaked:
- `ln_in_ready` is low whenever the FIFO is full (or the direction is write).
- `ln_out_valid` is low whenever the FIFO is empty (or the direction is read).
- A word moves only in a cycle where valid and ready are both high.
- Valid and data may be held across cycles while ready is low.

A byte/block counter is loaded with the bytes per block and the number of blocks. It counts 4 bytes for every word that crosses the line side. It raises a sticky block-done status bit each time a block completes, and it signals the end of the transfer when no blocks remain.

Top module: `sdf_data_fifo`

## Requirements
- R1: The FIFO stores up to 16 words of 32 bits in first-in first-out order. Its fill level (0..16) reads back at bits 8:4 of `mode_rdata`.
- R2: A `cfg_wr` pulse loads the write threshold from `cfg_wdata[13:9]` and the read threshold from `cfg_wdata[18:14]`. Both thresholds read back at the same positions of `mode_rdata`, both reset to 4, and all other bits of `mode_rdata` read as zero.
- R3: `rd_ready` is high exactly when fill >= read threshold. `wr_ready` is high exactly when (16 - fill) >= write threshold. Both comparisons cover the whole 0..31 threshold range.
- R4: With `dir_rd`=1, the line pushes `ln_in_data` on a cycle with `ln_in_valid` and `ln_in_ready` both high, and `ln_in_ready` = FIFO not full. `reg_rdata` shows the oldest word, and a `reg_rd` pulse pops it at the clock edge.
- R5: With `dir_rd`=0, `reg_wr` pushes `reg_wdata`. `ln_out_valid` = FIFO not empty, `ln_out_data` is the oldest word, and that word is removed on a cycle with `ln_out_valid` and `ln_out_ready` both high.
- R6: A `reg_rd` with `dir_rd`=1 on an empty FIFO sees `reg_rdata`=0, leaves the fill level unchanged and sets status bit 3 (FIFO error).
- R7: A `reg_wr` with `dir_rd`=0 on a full FIFO is dropped: the stored words and the fill level are unchanged, and status bit 3 is set.
- R8: `reg_wr` has no effect when `dir_rd`=1. `reg_rd` has no effect when `dir_rd`=0, and `reg_rdata` reads 0 in that direction.
- R9: Status bit 0 is high exactly when the FIFO holds at least one word. A `stat_clr_wr` pulse clears status bits 3 and 9 where `stat_clr_data` has a 1. A flag set in the same cycle as its clear stays set. All other status bits read as zero.
- R10: A `cnt_load` pulse loads the bytes per block and the block count, and clears the byte accumulator. While blocks remain, each word crossing the line side adds 4 bytes. When the accumulated bytes reach or pass the block size, the accumulator clears, `blocks_left` decrements and status bit 9 is set. `xfer_done` is high exactly when `blocks_left` is 0, and the count never wraps below zero.
- R11: After reset the FIFO is empty, both thresholds are 4, the status word is 0, `blocks_left` is 0 and `xfer_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_rd | input | 1 | 1: card-to-host, 0: host-to-card |
| reg_wr | input | 1 | Data register write strobe (push) |
| reg_wdata | input | 32 | Data register write word |
| reg_rd | input | 1 | Data register read strobe (pop) |
| reg_rdata | output | 32 | Oldest word, or 0 |
| ln_in_valid | input | 1 | Line-side push valid |
| ln_in_ready | output | 1 | Line-side push ready |
| ln_in_data | input | 32 | Line-side push word |
| ln_out_valid | output | 1 | Line-side drain valid |
| ln_out_ready | input | 1 | Line-side drain ready |
| ln_out_data | output | 32 | Line-side drain word |
| cfg_wr | input | 1 | Threshold load strobe |
| cfg_wdata | input | 32 | Threshold load word |
| mode_rdata | output | 32 | Fill level and thresholds |
| rd_ready | output | 1 | Fill at or above read threshold |
| wr_ready | output | 1 | Free space at or above write threshold |
| stat_clr_wr | input | 1 | Status clear strobe |
| stat_clr_data | input | 32 | Status clear mask (write 1 to clear) |
| stat_rdata | output | 32 | Status word: bit 0 data, bit 3 error, bit 9 block done |
| cnt_load | input | 1 | Counter load strobe |
| cnt_bytes | input | 16 | Bytes per block |
| cnt_blocks | input | 9 | Number of blocks |
| blocks_left | output | 9 | Blocks not yet completed |
| xfer_done | output | 1 | No blocks remain |

## Verification
Corruption of the read or write pointers shows up the next cycle in three places: the fill field, the data flag and the ready outputs. A pointer that skips or repeats an entry appears as a wrong word on `reg_rdata` or `ln_out_data` at the very next pop, so every popped word is compared against its pushed order. A bad threshold compare is exposed by sweeping every threshold value at every fill level. A miscounting byte accumulator shifts the cycle in which `blocks_left` drops and bit 9 rises, and those are checked after every single word.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  localparam int WORD_W         = 32;
  localparam int FIELD_W        = 5;
  localparam int FILL_LSB       = 4;
  localparam int WTHR_LSB       = 9;
  localparam int RTHR_LSB       = 14;
  localparam int ST_DATA        = 0;
  localparam int ST_FERR        = 3;
  localparam int ST_BLK         = 9;
  localparam int BYTES_PER_WORD = 4;
  localparam logic [FIELD_W-1:0] THR_RESET = 5'd4;
endpackage

// File: rtl/sdf_store.sv
module sdf_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] fill
);
  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] wptr, rptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr[AW-1:0]] <= push_data;
  end

  assign fill  = wptr - rptr;
  assign empty = (wptr == rptr);
  assign full  = (wptr[AW-1:0] == rptr[AW-1:0]) && (wptr[AW] != rptr[AW]);
  assign head  = mem[rptr[AW-1:0]];
endmodule

// File: rtl/sdf_level.sv
module sdf_level #(
  parameter int DEPTH = 16,
  parameter int FW    = 5,
  parameter int CW    = 5,
  localparam int XW   = ((FW > CW) ? FW : CW) + 1
) (
  input  logic [CW-1:0] fill,
  input  logic [FW-1:0] rthr,
  input  logic [FW-1:0] wthr,
  output logic          rd_ready,
  output logic          wr_ready
);
  logic [XW-1:0] fill_x, free_x, rthr_x, wthr_x;

  always_comb begin
    fill_x   = XW'(fill);
    free_x   = XW'(DEPTH) - fill_x;
    rthr_x   = XW'(rthr);
    wthr_x   = XW'(wthr);
    rd_ready = (fill_x >= rthr_x);
    wr_ready = (free_x >= wthr_x);
  end
endmodule

// File: rtl/sdf_blkcnt.sv
module sdf_blkcnt #(
  parameter int BCW  = 16,
  parameter int BLKW = 9,
  parameter int STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BCW-1:0]  load_bytes,
  input  logic [BLKW-1:0] load_blocks,
  input  logic            word_fire,
  output logic [BLKW-1:0] left,
  output logic            blk_done
);
  logic [BCW-1:0] acc, size_q;
  logic [BCW:0]   acc_next;
  logic           active, hit;

  always_comb begin
    acc_next = {1'b0, acc} + (BCW+1)'(STEP);
    hit      = (acc_next >= {1'b0, size_q});
    active   = (left != '0);
    blk_done = !load && word_fire && active && hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      size_q <= '0;
      left   <= '0;
    end else if (load) begin
      acc    <= '0;
      size_q <= load_bytes;
      left   <= load_blocks;
    end else if (word_fire && active) begin
      if (hit) begin
        acc  <= '0;
        left <= left - 1'b1;
      end else begin
        acc  <= acc_next[BCW-1:0];
      end
    end
  end
endmodule

// File: rtl/sdf_data_fifo.sv
module sdf_data_fifo
  import sdf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int BCW   = 16,
  parameter int BLKW  = 9,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dir_rd,
  input  logic            reg_wr,
  input  logic [31:0]     reg_wdata,
  input  logic            reg_rd,
  output logic [31:0]     reg_rdata,
  input  logic            ln_in_valid,
  output logic            ln_in_ready,
  input  logic [31:0]     ln_in_data,
  output logic            ln_out_valid,
  input  logic            ln_out_ready,
  output logic [31:0]     ln_out_data,
  input  logic            cfg_wr,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     mode_rdata,
  output logic            rd_ready,
  output logic            wr_ready,
  input  logic            stat_clr_wr,
  input  logic [31:0]     stat_clr_data,
  output logic [31:0]     stat_rdata,
  input  logic            cnt_load,
  input  logic [BCW-1:0]  cnt_bytes,
  input  logic [BLKW-1:0] cnt_blocks,
  output logic [BLKW-1:0] blocks_left,
  output logic            xfer_done
);
  logic [WORD_W-1:0]  head, push_data;
  logic               empty, full, push, pop;
  logic [CW-1:0]      fill;
  logic               reg_push_req, reg_pop_req, in_fire, out_fire;
  logic               ferr_set, blk_set, ferr_q, blk_q;
  logic [FIELD_W-1:0] rthr_q, wthr_q;

  // Direction steering: each direction has exactly one push and one pop source.
  always_comb begin
    reg_push_req = reg_wr && !dir_rd;
    reg_pop_req  = reg_rd && dir_rd;
    ln_in_ready  = dir_rd && !full;
    ln_out_valid = !dir_rd && !empty;
    in_fire      = ln_in_valid && ln_in_ready;
    out_fire     = ln_out_valid && ln_out_ready;
    push         = dir_rd ? in_fire : (reg_push_req && !full);
    push_data    = dir_rd ? ln_in_data : reg_wdata;
    pop          = dir_rd ? (reg_pop_req && !empty) : out_fire;
    ferr_set     = (reg_pop_req && empty) || (reg_push_req && full);
    reg_rdata    = (dir_rd && !empty) ? head : '0;
    ln_out_data  = head;
  end

  sdf_store #(.DW(WORD_W), .DEPTH(DEPTH)) store_i (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .pop(pop), .head(head), .empty(empty), .full(full), .fill(fill)
  );

  sdf_level #(.DEPTH(DEPTH), .FW(FIELD_W), .CW(CW)) level_i (
    .fill(fill), .rthr(rthr_q), .wthr(wthr_q),
    .rd_ready(rd_ready), .wr_ready(wr_ready)
  );

  sdf_blkcnt #(.BCW(BCW), .BLKW(BLKW), .STEP(BYTES_PER_WORD)) blkcnt_i (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_bytes(cnt_bytes),
    .load_blocks(cnt_blocks), .word_fire(in_fire || out_fire),
    .left(blocks_left), .blk_done(blk_set)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rthr_q <= THR_RESET;
      wthr_q <= THR_RESET;
    end else if (cfg_wr) begin
      rthr_q <= cfg_wdata[RTHR_LSB +: FIELD_W];
      wthr_q <= cfg_wdata[WTHR_LSB +: FIELD_W];
    end
  end

  // Sticky flags: a set in the same cycle wins over a clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ferr_q <= 1'b0;
      blk_q  <= 1'b0;
    end else begin
      ferr_q <= (ferr_q && !(stat_clr_wr && stat_clr_data[ST_FERR])) || ferr_set;
      blk_q  <= (blk_q  && !(stat_clr_wr && stat_clr_data[ST_BLK]))  || blk_set;
    end
  end

  always_comb begin
    mode_rdata = '0;
    mode_rdata[FILL_LSB +: FIELD_W] = FIELD_W'(fill);
    mode_rdata[WTHR_LSB +: FIELD_W] = wthr_q;
    mode_rdata[RTHR_LSB +: FIELD_W] = rthr_q;
    stat_rdata = '0;
    stat_rdata[ST_DATA] = !empty;
    stat_rdata[ST_FERR] = ferr_q;
    stat_rdata[ST_BLK]  = blk_q;
    xfer_done = (blocks_left == '0);
  end
endmodule

// File: rtl/sdf_data_fifo_chk.sv
module sdf_data_fifo_chk #(
  parameter int BLKW = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dir_rd,
  input logic            reg_wr,
  input logic            reg_rd,
  input logic            ln_in_ready,
  input logic            ln_out_valid,
  input logic            cnt_load,
  input logic [31:0]     mode_rdata,
  input logic [31:0]     stat_rdata,
  input logic [BLKW-1:0] blocks_left
);
  logic [4:0] lvl;
  assign lvl = mode_rdata[8:4];

  assert_fill_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= 5'd16);

  assert_in_backpressure_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == 5'd16) |-> !ln_in_ready);

  assert_out_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_rd && lvl != 5'd0) |-> ln_out_valid);

  assert_underflow_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_rd && reg_rd && lvl == 5'd0) |=> stat_rdata[3]);

  assert_overflow_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_rd && reg_wr && lvl == 5'd16) |=> stat_rdata[3]);

  assert_data_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rdata[0] == (lvl != 5'd0));

  assert_blocks_no_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_load |=> blocks_left <= $past(blocks_left));
endmodule

bind sdf_data_fifo sdf_data_fifo_chk #(.BLKW(BLKW)) chk_i (
  .clk(clk), .rst_n(rst_n), .dir_rd(dir_rd), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .ln_in_ready(ln_in_ready), .ln_out_valid(ln_out_valid), .cnt_load(cnt_load),
  .mode_rdata(mode_rdata), .stat_rdata(stat_rdata), .blocks_left(blocks_left)
);

// File: tb/sdf_data_fifo_tb_top.sv
module sdf_data_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dir_rd = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        ln_in_valid = 1'b0, ln_in_ready;
  logic [31:0] ln_in_data = '0;
  logic        ln_out_valid, ln_out_ready = 1'b0;
  logic [31:0] ln_out_data;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0, mode_rdata;
  logic        rd_ready, wr_ready;
  logic        stat_clr_wr = 1'b0;
  logic [31:0] stat_clr_data = '0, stat_rdata;
  logic        cnt_load = 1'b0;
  logic [15:0] cnt_bytes = '0;
  logic [8:0]  cnt_blocks = '0, blocks_left;
  logic        xfer_done;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  sdf_data_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .dir_rd(dir_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .ln_in_valid(ln_in_valid), .ln_in_ready(ln_in_ready), .ln_in_data(ln_in_data),
    .ln_out_valid(ln_out_valid), .ln_out_ready(ln_out_ready), .ln_out_data(ln_out_data),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .mode_rdata(mode_rdata),
    .rd_ready(rd_ready), .wr_ready(wr_ready),
    .stat_clr_wr(stat_clr_wr), .stat_clr_data(stat_clr_data), .stat_rdata(stat_rdata),
    .cnt_load(cnt_load), .cnt_bytes(cnt_bytes), .cnt_blocks(cnt_blocks),
    .blocks_left(blocks_left), .xfer_done(xfer_done)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] fillv();
    return {27'd0, mode_rdata[8:4]};
  endfunction

  task automatic line_push(logic [31:0] d);
    ln_in_valid = 1'b1; ln_in_data = d; tick(); ln_in_valid = 1'b0;
  endtask

  task automatic set_thr(int r, int w);
    cfg_wr = 1'b1;
    cfg_wdata = (32'(r) << 14) | (32'(w) << 9);
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic clr_stat(logic [31:0] m);
    stat_clr_wr = 1'b1; stat_clr_data = m; tick(); stat_clr_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R11 reset state
    check("R11 mode word", mode_rdata, 32'h0001_0800);
    check("R11 status", stat_rdata, 32'h0);
    check("R11 blocks_left", {23'd0, blocks_left}, 32'd0);
    check("R11 xfer_done", {31'd0, xfer_done}, 32'd1);

    // R1 R2 R3 R4: sweep every threshold value at every fill level
    dir_rd = 1'b1;
    for (int k = 0; k <= 16; k++) begin
      for (int t = 0; t < 32; t++) begin
        set_thr(t, 31 - t);
        check("R1 fill field", fillv(), 32'(k));
        check("R2 readback", mode_rdata, (32'(t) << 14) | (32'(31 - t) << 9) | (32'(k) << 4));
        check("R3 rd_ready", {31'd0, rd_ready}, {31'd0, (k >= t)});
        check("R3 wr_ready", {31'd0, wr_ready}, {31'd0, ((16 - k) >= (31 - t))});
        check("R4 ln_in_ready", {31'd0, ln_in_ready}, {31'd0, (k < 16)});
      end
      if (k < 16) line_push(32'hA500_0000 + 32'(k));
    end
    line_push(32'hBAD0_0000);
    check("R4 full blocks push", fillv(), 32'd16);

    for (int k = 0; k < 16; k++) begin
      check("R1 R4 pop order", reg_rdata, 32'hA500_0000 + 32'(k));
      check("R9 data flag set", {31'd0, stat_rdata[0]}, 32'd1);
      reg_rd = 1'b1; tick(); reg_rd = 1'b0;
      check("R4 fill after pop", fillv(), 32'(15 - k));
    end
    check("R9 data flag clear", {31'd0, stat_rdata[0]}, 32'd0);
    check("R6 no error yet", {31'd0, stat_rdata[3]}, 32'd0);
    check("R6 empty rdata", reg_rdata, 32'd0);
    reg_rd = 1'b1; tick(); reg_rd = 1'b0;
    check("R6 error set", {31'd0, stat_rdata[3]}, 32'd1);
    check("R6 fill unchanged", fillv(), 32'd0);
    clr_stat(32'h8);
    check("R9 clear error", stat_rdata, 32'd0);
    reg_rd = 1'b1; stat_clr_wr = 1'b1; stat_clr_data = 32'h8;
    tick();
    reg_rd = 1'b0; stat_clr_wr = 1'b0;
    check("R9 set beats clear", {31'd0, stat_rdata[3]}, 32'd1);
    clr_stat(32'h208);

    // R5 R7 R8: host-to-card direction
    dir_rd = 1'b0;
    tick();
    check("R8 line push closed", {31'd0, ln_in_ready}, 32'd0);
    for (int i = 0; i < 16; i++) begin
      reg_wr = 1'b1; reg_wdata = 32'hC0DE_0000 + 32'(i); tick();
    end
    reg_wr = 1'b0;
    check("R5 fill after writes", fillv(), 32'd16);
    check("R7 no error yet", {31'd0, stat_rdata[3]}, 32'd0);
    reg_wr = 1'b1; reg_wdata = 32'hDEAD_BEEF; tick(); reg_wr = 1'b0;
    check("R7 error set", {31'd0, stat_rdata[3]}, 32'd1);
    check("R7 fill unchanged", fillv(), 32'd16);
    reg_rd = 1'b1; tick(); reg_rd = 1'b0;
    check("R8 reg_rd ignored", fillv(), 32'd16);
    check("R8 rdata zero", reg_rdata, 32'd0);
    for (int i = 0; i < 16; i++) begin
      check("R5 out valid", {31'd0, ln_out_valid}, 32'd1);
      check("R5 R7 drain order", ln_out_data, 32'hC0DE_0000 + 32'(i));
      ln_out_ready = 1'b1; tick(); ln_out_ready = 1'b0;
    end
    check("R5 R7 drained", {31'd0, ln_out_valid}, 32'd0);
    dir_rd = 1'b1;
    reg_wr = 1'b1; reg_wdata = 32'h1234_5678; tick(); reg_wr = 1'b0;
    check("R8 reg_wr ignored", fillv(), 32'd0);
    clr_stat(32'h208);

    // R10: read direction, 8-byte blocks, 3 blocks
    cnt_load = 1'b1; cnt_bytes = 16'd8; cnt_blocks = 9'd3; tick(); cnt_load = 1'b0;
    check("R10 load", {23'd0, blocks_left}, 32'd3);
    check("R10 not done", {31'd0, xfer_done}, 32'd0);
    for (int n = 1; n <= 7; n++) begin
      int exp_left;
      exp_left = 3 - n / 2;
      if (exp_left < 0) exp_left = 0;
      line_push(32'h5500_0000 + 32'(n));
      check("R10 blocks_left", {23'd0, blocks_left}, 32'(exp_left));
      check("R10 block flag", {31'd0, stat_rdata[9]}, {31'd0, (n >= 2 && n <= 6 && n % 2 == 0)});
      check("R10 done", {31'd0, xfer_done}, {31'd0, (exp_left == 0)});
      if (stat_rdata[9]) clr_stat(32'h200);
    end
    // R10: write direction, 12-byte blocks, 2 blocks, drain 6 of the 7 words
    dir_rd = 1'b0;
    cnt_load = 1'b1; cnt_bytes = 16'd12; cnt_blocks = 9'd2; tick(); cnt_load = 1'b0;
    for (int n = 1; n <= 6; n++) begin
      ln_out_ready = 1'b1; tick(); ln_out_ready = 1'b0;
      check("R10 drain blocks_left", {23'd0, blocks_left}, 32'(2 - n / 3));
      check("R10 drain flag", {31'd0, stat_rdata[9]}, {31'd0, (n % 3 == 0)});
      if (stat_rdata[9]) clr_stat(32'h200);
    end
    check("R10 drain done", {31'd0, xfer_done}, 32'd1);
    check("R1 leftover word", fillv(), 32'd1);
    finish_run();
  end
endmodule